// File: doc/BRIEF.md
# Scrambled Cell-Walk Memory Tester

This block is an on-chip pattern generator for memory test. It steps through the physical cell array of a memory. The column is the fast coordinate and the row is the slow one. For every cell it computes the device address that reaches that cell, so cells that sit next to each other on silicon are visited one after another. It makes the write data, the write and read commands and the expected read word from loop counters alone. No vectors are stored. It compares each returned word one cycle after the read and reports any mismatch with its device address, its physical coordinates and both words.

A run is started from idle and makes one full write pass followed by one full read pass. Two data patterns are offered. The solid pattern writes one uniform word. The checkerboard pattern alternates all-ones and all-zeros words by physical cell parity. Either pattern can be inverted. On a mismatch the run either continues to the end or, if stop-on-fail was selected, halts at once.

The controller has four states: `ST_IDLE`, `ST_WRITE`, `ST_READ` and `ST_DRAIN`. Its transitions are:
- `ST_IDLE`→`ST_WRITE` on `start`. This latches the mode and clears the walk.
- `ST_WRITE`→`ST_READ` after the last cell is written.
- `ST_READ`→`ST_DRAIN` after the last cell is read.
- `ST_READ`→`ST_IDLE` or `ST_DRAIN`→`ST_IDLE` on a failure with stop-on-fail set.
- `ST_DRAIN`→`ST_IDLE` in every other case, with `done` raised.

Top module: `cellwalk_tester`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `mem_wr`, `mem_rd`, `done` and `fail` are all low.
- R2: The device address is `{x_msb, y_msb, xa_low, ya_low}`, with the column-low field above the row-low field. Here `ya_low = y_low XOR {y_msb...}` and `ya_msb = y_msb`. At the default 9-bit row and 8-bit column, physical (y=256, x=128) maps to 0x180FF.
- R3: The column-low field is `xa_low = x_low XOR {NOT x_msb...}` and `xa_msb = x_msb`. At the defaults, physical (0,0) maps to 0x07F00.
- R4: Each pass visits cells in row-major order: x is the inner count and y the outer. Every device address is used exactly once per pass.
- R5: A `start` seen in idle gives N write cycles, then N read cycles, then one cycle with `done` high. `done` is therefore in the (2N+1)th cycle after the start edge. `busy` is high throughout, and `start` has no effect while `busy` is high.
- R6: With `pattern_sel`=0 (solid), every word is all zeros, or all ones when `invert`=1.
- R7: With `pattern_sel`=1 (checkerboard), a cell's word is all ones when `x[0] XOR y[0] XOR invert` is 1 and all zeros otherwise.
- R8: One cycle after a read, if `rd_data` differs from the expected word, `fail` is high. In that cycle `fail_addr`, `fail_x`, `fail_y`, `fail_exp` and `fail_act` give the read's device address, its coordinates, the expected word and the word returned. Matching reads raise no `fail`.
- R9: With `stop_on_fail`=0, every bad read gives its own `fail` cycle, and the run still completes with `done`.
- R10: With `stop_on_fail`=1, the block is idle in the cycle after `fail`, issues no further read and raises no `done`.
- R11: `mem_wr` and `mem_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (honoured in idle only) |
| pattern_sel | input | 1 | 0 solid, 1 checkerboard |
| invert | input | 1 | Invert the data pattern |
| stop_on_fail | input | 1 | Halt at the first mismatch |
| rd_data | input | DATA_W | Word returned by the memory one cycle after `mem_rd` |
| mem_addr | output | ROW_BITS+COL_BITS | Device address of the current cell |
| mem_wr | output | 1 | Write command |
| mem_rd | output | 1 | Read command |
| mem_wdata | output | DATA_W | Write data (also the expected word) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a complete run |
| fail | output | 1 | Mismatch strobe |
| fail_addr | output | ROW_BITS+COL_BITS | Device address of the failing read |
| fail_x | output | COL_BITS | Physical column of the failing read |
| fail_y | output | ROW_BITS | Physical row of the failing read |
| fail_exp | output | DATA_W | Expected word |
| fail_act | output | DATA_W | Word returned |

## Verification
The assertions assume that the memory returns `rd_data` exactly one cycle after each `mem_rd`. They also assume that `pattern_sel`, `invert` and `stop_on_fail` matter only in the start cycle, since they are latched there. The stimulus keeps to this by using a bench memory with a registered read port, which injects errors only by flipping bit 0 of chosen addresses. All inputs are driven on the falling edge, and every run begins from idle. One run pulses `start` in the middle of the write pass to show that it is ignored.

// File: rtl/cellwalk_pkg.sv
package cellwalk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_DRAIN = 2'd3
    } walk_state_t;

    typedef enum logic {
        PAT_SOLID   = 1'b0,
        PAT_CHECKER = 1'b1
    } pattern_t;

    // Level of every bit of the word stored in one cell.
    function automatic logic cell_level(pattern_t pat, logic inv, logic x0, logic y0);
        if (pat == PAT_CHECKER) begin
            return x0 ^ y0 ^ inv;
        end
        return inv;
    endfunction

endpackage

// File: rtl/cellwalk_walker.sv
module cellwalk_walker #(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                adv,
    output logic [COL_BITS-1:0] x,
    output logic [ROW_BITS-1:0] y,
    output logic                last
);
    localparam int CELL_W = ROW_BITS + COL_BITS;

    logic [COL_BITS-1:0] x_q;
    logic [ROW_BITS-1:0] y_q;
    logic [CELL_W-1:0]   cell_idx;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            x_q <= '0;
            y_q <= '0;
        end else if (adv) begin
            if (&x_q) begin
                x_q <= '0;
                y_q <= y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    assign x        = x_q;
    assign y        = y_q;
    assign last     = (&x_q) && (&y_q);
    assign cell_idx = {y_q, x_q};

    AST_ROW_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clear && !last) |=> (cell_idx == $past(cell_idx) + CELL_W'(1))); // R4

endmodule

// File: rtl/cellwalk_scramble.sv
module cellwalk_scramble #(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 8
) (
    input  logic [COL_BITS-1:0]          x,
    input  logic [ROW_BITS-1:0]          y,
    output logic [ROW_BITS+COL_BITS-1:0] dev_addr
);
    logic [ROW_BITS-2:0] ya_low;
    logic [COL_BITS-2:0] xa_low;

    // The row half mirrors when the row block bit is set.
    assign ya_low = y[ROW_BITS-2:0] ^ {(ROW_BITS-1){y[ROW_BITS-1]}};
    // The column half mirrors when the column block bit is clear.
    assign xa_low = x[COL_BITS-2:0] ^ {(COL_BITS-1){~x[COL_BITS-1]}};

    assign dev_addr = {x[COL_BITS-1], y[ROW_BITS-1], xa_low, ya_low};

endmodule

// File: rtl/cellwalk_compare.sv
module cellwalk_compare #(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 8,
    parameter int DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         issue,
    input  logic [ROW_BITS+COL_BITS-1:0] issue_addr,
    input  logic [COL_BITS-1:0]          issue_x,
    input  logic [ROW_BITS-1:0]          issue_y,
    input  logic [DATA_W-1:0]            issue_exp,
    input  logic [DATA_W-1:0]            rd_data,
    output logic                         fail,
    output logic [ROW_BITS+COL_BITS-1:0] fail_addr,
    output logic [COL_BITS-1:0]          fail_x,
    output logic [ROW_BITS-1:0]          fail_y,
    output logic [DATA_W-1:0]            fail_exp,
    output logic [DATA_W-1:0]            fail_act
);
    logic                         pend_q;
    logic [ROW_BITS+COL_BITS-1:0] addr_q;
    logic [COL_BITS-1:0]          x_q;
    logic [ROW_BITS-1:0]          y_q;
    logic [DATA_W-1:0]            exp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            exp_q  <= '0;
        end else begin
            pend_q <= issue;
            if (issue) begin
                addr_q <= issue_addr;
                x_q    <= issue_x;
                y_q    <= issue_y;
                exp_q  <= issue_exp;
            end
        end
    end

    assign fail      = pend_q && (rd_data != exp_q);
    assign fail_addr = addr_q;
    assign fail_x    = x_q;
    assign fail_y    = y_q;
    assign fail_exp  = exp_q;
    assign fail_act  = rd_data;

    AST_FAIL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(issue)); // R8

endmodule

// File: rtl/cellwalk_tester.sv
module cellwalk_tester
    import cellwalk_pkg::*;
#(
    parameter int ROW_BITS = 9,
    parameter int COL_BITS = 8,
    parameter int DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         pattern_sel,
    input  logic                         invert,
    input  logic                         stop_on_fail,
    input  logic [DATA_W-1:0]            rd_data,
    output logic [ROW_BITS+COL_BITS-1:0] mem_addr,
    output logic                         mem_wr,
    output logic                         mem_rd,
    output logic [DATA_W-1:0]            mem_wdata,
    output logic                         busy,
    output logic                         done,
    output logic                         fail,
    output logic [ROW_BITS+COL_BITS-1:0] fail_addr,
    output logic [COL_BITS-1:0]          fail_x,
    output logic [ROW_BITS-1:0]          fail_y,
    output logic [DATA_W-1:0]            fail_exp,
    output logic [DATA_W-1:0]            fail_act
);
    localparam int ADDR_W = ROW_BITS + COL_BITS;

    walk_state_t         state_q, state_d;
    pattern_t            pat_q;
    logic                inv_q, stop_q;
    logic [COL_BITS-1:0] cur_x;
    logic [ROW_BITS-1:0] cur_y;
    logic                last_cell;
    logic                walk_clear, walk_adv;
    logic [ADDR_W-1:0]   dev_addr;
    logic [DATA_W-1:0]   exp_word;
    logic                halt;

    cellwalk_walker #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_walker (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (walk_clear),
        .adv   (walk_adv),
        .x     (cur_x),
        .y     (cur_y),
        .last  (last_cell)
    );

    cellwalk_scramble #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_scramble (
        .x        (cur_x),
        .y        (cur_y),
        .dev_addr (dev_addr)
    );

    cellwalk_compare #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_compare (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (mem_rd),
        .issue_addr (dev_addr),
        .issue_x    (cur_x),
        .issue_y    (cur_y),
        .issue_exp  (exp_word),
        .rd_data    (rd_data),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_x     (fail_x),
        .fail_y     (fail_y),
        .fail_exp   (fail_exp),
        .fail_act   (fail_act)
    );

    assign exp_word = {DATA_W{cell_level(pat_q, inv_q, cur_x[0], cur_y[0])}};
    assign halt     = fail && stop_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Run configuration, captured when a run begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q  <= PAT_SOLID;
            inv_q  <= 1'b0;
            stop_q <= 1'b0;
        end else if (state_q == ST_IDLE && start) begin
            pat_q  <= pattern_t'(pattern_sel);
            inv_q  <= invert;
            stop_q <= stop_on_fail;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_WRITE;
            ST_WRITE: if (last_cell) state_d = ST_READ;
            ST_READ: begin
                if (halt)           state_d = ST_IDLE;
                else if (last_cell) state_d = ST_DRAIN;
            end
            ST_DRAIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs per state.
    always_comb begin
        walk_clear = 1'b0;
        walk_adv   = 1'b0;
        mem_wr     = 1'b0;
        mem_rd     = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE:  walk_clear = start;
            ST_WRITE: begin
                mem_wr   = 1'b1;
                walk_adv = 1'b1;
            end
            ST_READ: begin
                mem_rd   = !halt;
                walk_adv = !halt;
            end
            ST_DRAIN: done = !halt;
            default: ;
        endcase
    end

    assign mem_addr  = dev_addr;
    assign mem_wdata = exp_word;
    assign busy      = (state_q != ST_IDLE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd)); // R5
    AST_WRITE_INTO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (mem_wr || mem_rd)); // R5
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && stop_q) |=> (!busy && !mem_rd && !done)); // R10

endmodule

// File: tb/cellwalk_tester_bench.sv
module cellwalk_tester_bench;
    localparam int RB = 4;
    localparam int CB = 3;
    localparam int DW = 8;
    localparam int AW = RB + CB;
    localparam int NC = 1 << AW;
    localparam int XN = 1 << CB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          pattern_sel = 1'b0;
    logic          invert = 1'b0;
    logic          stop_on_fail = 1'b0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic          mem_wr, mem_rd;
    logic [DW-1:0] mem_wdata;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [CB-1:0] fail_x;
    logic [RB-1:0] fail_y;
    logic [DW-1:0] fail_exp, fail_act;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cellwalk_tester #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) u_cellwalk_tester (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern_sel(pattern_sel),
        .invert(invert), .stop_on_fail(stop_on_fail), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_x(fail_x), .fail_y(fail_y), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    // Synchronous memory model with per-address bit-0 corruption on read.
    logic [DW-1:0] mem [NC];
    logic [NC-1:0] flip_mask = '0;
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) rd_data <= mem[mem_addr] ^ DW'(flip_mask[mem_addr]);
    end

    // Run records.
    logic [AW-1:0] wr_addr [NC];
    logic [DW-1:0] wr_word [NC];
    logic [AW-1:0] rd_addr [NC];
    logic [AW-1:0] f_addr [4];
    logic [CB-1:0] f_x [4];
    logic [RB-1:0] f_y [4];
    logic [DW-1:0] f_exp [4], f_act [4];
    int wr_n, rd_n, f_n, done_n, both_n, done_cyc, end_cyc;

    function automatic logic [AW-1:0] scr(int x, int y);
        logic [RB-1:0] yy;
        logic [CB-1:0] xx;
        logic [RB-2:0] yl;
        logic [CB-2:0] xl;
        yy = RB'(y);
        xx = CB'(x);
        yl = yy[RB-2:0] ^ {(RB-1){yy[RB-1]}};
        xl = xx[CB-2:0] ^ {(CB-1){~xx[CB-1]}};
        return {xx[CB-1], yy[RB-1], xl, yl};
    endfunction

    function automatic logic [DW-1:0] pat_word(logic chk, logic inv, int x, int y);
        logic lvl;
        lvl = chk ? (1'(x) ^ 1'(y) ^ inv) : inv;
        return {DW{lvl}};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic chk, input logic inv, input logic stp, input int mid);
        int cyc;
        wr_n = 0; rd_n = 0; f_n = 0; done_n = 0; both_n = 0; done_cyc = 0;
        for (int i = 0; i < NC; i++) mem[i] = 8'h5A;
        @(negedge clk);
        pattern_sel = chk; invert = inv; stop_on_fail = stp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (cyc < 4 * NC) begin
            if (!busy) break;
            if (mem_wr && mem_rd) both_n++;
            if (mem_wr && wr_n < NC) begin wr_addr[wr_n] = mem_addr; wr_word[wr_n] = mem_wdata; wr_n++; end
            if (mem_rd && rd_n < NC) begin rd_addr[rd_n] = mem_addr; rd_n++; end
            if (done) begin done_n++; done_cyc = cyc; end
            if (fail && f_n < 4) begin
                f_addr[f_n] = fail_addr; f_x[f_n] = fail_x; f_y[f_n] = fail_y;
                f_exp[f_n] = fail_exp; f_act[f_n] = fail_act; f_n++;
            end
            start = (cyc == mid);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        end_cyc = cyc;
        check(cyc < 4 * NC, "R5", "run ended before limit", cyc, 4 * NC);
    endtask

    // Checks shared by complete error-free runs.
    task automatic check_clean_run(input logic chk, input logic inv, input string dreq);
        int bad_wa, bad_wd, bad_ra, bad_mem;
        logic [NC-1:0] seen;
        bad_wa = 0; bad_wd = 0; bad_ra = 0; bad_mem = 0; seen = '0;
        check(done_cyc == 2 * NC + 1, "R5", "done cycle", done_cyc, 2 * NC + 1);
        check(done_n == 1, "R5", "done pulses", done_n, 1);
        check(wr_n == NC && rd_n == NC, "R4", "write/read counts", wr_n * 1000 + rd_n, NC * 1001);
        for (int i = 0; i < NC; i++) begin
            if (wr_addr[i] != scr(i % XN, i / XN)) bad_wa++;
            if (rd_addr[i] != scr(i % XN, i / XN)) bad_ra++;
            if (wr_word[i] != pat_word(chk, inv, i % XN, i / XN)) bad_wd++;
            if (mem[scr(i % XN, i / XN)] != pat_word(chk, inv, i % XN, i / XN)) bad_mem++;
            seen[wr_addr[i]] = 1'b1;
        end
        check(bad_wa == 0, "R2", "write address order mismatches", bad_wa, 0);
        check(bad_ra == 0, "R4", "read address order mismatches", bad_ra, 0);
        check(&seen, "R4", "every device address written", $countones(seen), NC);
        check(bad_wd == 0, dreq, "write data mismatches", bad_wd, 0);
        check(bad_mem == 0, dreq, "memory contents mismatches", bad_mem, 0);
        check(f_n == 0, "R8", "fail strobes on clean memory", f_n, 0);
        check(both_n == 0, "R11", "cycles with write and read", both_n, 0);
    endtask

    task automatic t_reset();
        check({busy, mem_wr, mem_rd, done, fail} == 5'b0, "R1", "outputs in reset",
              {busy, mem_wr, mem_rd, done, fail}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, mem_wr, mem_rd, done, fail} == 5'b0, "R1", "outputs after reset",
              {busy, mem_wr, mem_rd, done, fail}, 0);
    endtask

    task automatic t_solid();
        run(1'b0, 1'b0, 1'b0, 0);
        check_clean_run(1'b0, 1'b0, "R6");
        // start pulsed mid-run must not restart or stretch the run
        run(1'b0, 1'b1, 1'b0, 50);
        check_clean_run(1'b0, 1'b1, "R6");
    endtask

    task automatic t_checker();
        run(1'b1, 1'b0, 1'b0, 0);
        check_clean_run(1'b1, 1'b0, "R7");
        // R3: x=0,y=0 -> column low bits inverted: 0011000
        check(wr_addr[0] == 7'h18, "R3", "address of cell (0,0)", wr_addr[0], 7'h18);
        // R2: x=0,y=1 -> 0011001; x=7,y=15 -> row low mirrored: 1111000
        check(wr_addr[XN] == 7'h19, "R2", "address of cell (0,1)", wr_addr[XN], 7'h19);
        check(wr_addr[NC-1] == 7'h78, "R2", "address of last cell", wr_addr[NC-1], 7'h78);
        run(1'b1, 1'b1, 1'b0, 0);
        check_clean_run(1'b1, 1'b1, "R7");
    endtask

    task automatic t_fail_continue();
        flip_mask = '0;
        flip_mask[scr(5, 0)] = 1'b1;
        flip_mask[scr(6, 8)] = 1'b1;
        run(1'b0, 1'b0, 1'b0, 0);
        check(f_n == 2, "R9", "fail count", f_n, 2);
        check(done_n == 1 && done_cyc == 2 * NC + 1, "R9", "done still at end", done_cyc, 2 * NC + 1);
        check(f_addr[0] == scr(5, 0) && f_x[0] == 3'd5 && f_y[0] == 4'd0, "R8",
              "first fail location", {f_addr[0], f_x[0], f_y[0]}, {scr(5, 0), 3'd5, 4'd0});
        check(f_exp[0] == 8'h00 && f_act[0] == 8'h01, "R8", "first fail words",
              {f_exp[0], f_act[0]}, 16'h0001);
        check(f_addr[1] == scr(6, 8) && f_x[1] == 3'd6 && f_y[1] == 4'd8, "R8",
              "second fail location", {f_addr[1], f_x[1], f_y[1]}, {scr(6, 8), 3'd6, 4'd8});
        flip_mask = '0;
    endtask

    task automatic t_fail_stop();
        flip_mask = '0;
        flip_mask[scr(4, 2)] = 1'b1;  // cell index 20
        run(1'b1, 1'b1, 1'b1, 0);
        check(f_n == 1, "R10", "single fail before halt", f_n, 1);
        check(done_n == 0, "R10", "no done after halt", done_n, 0);
        check(rd_n == 21, "R10", "reads issued before halt", rd_n, 21);
        check(end_cyc == NC + 23, "R10", "idle cycle after fail", end_cyc, NC + 23);
        check(f_exp[0] == 8'hFF && f_act[0] == 8'hFE, "R7", "inverted checker expected word",
              {f_exp[0], f_act[0]}, 16'hFFFE);
        flip_mask = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_solid();
        t_checker();
        t_fail_continue();
        t_fail_stop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule